// File: doc/BRIEF.md
# Virtual Command PASID Allocator Unit

This unit lets software obtain and release process address space identifiers through a small register window. Software writes a command word; the unit raises an in-progress flag in its response word, works for a fixed number of cycles, then clears the flag. When the flag clears, the response word also holds a two-bit status and, for a successful allocation, the identifier that was granted. Only one command can be in flight at a time. A command written while one is already running is dropped. A command written while the allocation capability strap is low is also dropped.

The identifiers come from an internal pool tracked by one bit per identifier. The pool covers identifiers 1 up to `POOL_SIZE-1`. Identifier 0 is reserved and never handed out. Allocation always returns the lowest free identifier. The register bus takes 32-bit accesses (the upper half of a register sits at offset +4) and 64-bit accesses. Reads are combinational from the address.

Top module: `vcmd_pasid_unit`

## Requirements
- R1: After reset, the command register and the response word read as zero and the pool holds no identifiers.
- R2: Offset 0xE00 reads the capability word, with bit 0 equal to the `capEn` strap and all other bits zero. Writes to 0xE00 and 0xE20 change nothing.
- R3: A command write to 0xE10 that is accepted sets response bit 0 (in progress) and clears the rest of the response. Bit 0 stays set for exactly `PROC_CYCLES` cycles and then clears.
- R4: A command write that arrives while response bit 0 is set is ignored. The command register keeps its value and the running command finishes unchanged.
- R5: A command write made while `capEn` is low is ignored. The command register is unchanged and response bit 0 stays clear.
- R6: Command bits [7:0] equal to 1 allocate. The lowest free identifier is marked used, response bits [2:1] become 0, and response bits [27:8] hold that identifier.
- R7: Identifier 0 is never allocated. An allocate with no free identifier gives status 2 (bits [2:1]) with result 0.
- R8: Command bits [7:0] equal to 2 free the identifier in command bits [27:8]. If that identifier is allocated, it becomes free, status is 0 and the result is 0, and a later allocate can return it.
- R9: A free of identifier 0, of an identifier at or above `POOL_SIZE`, or of one not currently allocated gives status 2 and leaves the pool unchanged.
- R10: Any other value of command bits [7:0], including 0, gives status 1 with result 0.
- R11: A 32-bit access at offset +4 reaches bits [63:32]. A 32-bit access at the base offset reaches bits [31:0], and a 32-bit write there leaves the other half as it was. A 32-bit write to either half of the command register is a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capEn | input | 1 | Strap that enables allocation commands and is shown in the capability word |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regWide | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| regAddr | input | 12 | Byte offset of the access |
| regWrData | input | 64 | Write data; a 32-bit write uses bits [31:0] |
| regRdData | output | 64 | Read data; a 32-bit read returns the selected half in bits [31:0] |

## Verification
The bench targets these corner cases:
- Reuse of a freed identifier in the middle of the range. A design that searched from the last grant instead of from the bottom would return a higher identifier here.
- Pool exhaustion up to the top identifier, then one more allocate. An off-by-one in the range would either grant identifier 0 or `POOL_SIZE`, or report failure one slot too early.
- Frees of identifier 0, of an out-of-range identifier and of an identifier already released. Each must give status 2. A design that cleared the bit without checking would corrupt later grants.
- Command writes while the unit is busy, while the capability is off, and as a 32-bit write to the upper half. Each shows whether the gating and the half-word merging alter the command register when they should not, or fail to when they should.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
  localparam logic [11:0] CAP_OFS = 12'hE00;
  localparam logic [11:0] CMD_OFS = 12'hE10;
  localparam logic [11:0] RSP_OFS = 12'hE20;

  localparam logic [7:0] OP_ALLOC = 8'd1;
  localparam logic [7:0] OP_FREE  = 8'd2;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_UNDEF = 2'd1;
  localparam logic [1:0] ST_FAIL  = 2'd2;

  localparam int ID_W = 20;

  typedef struct packed {
    logic accept;  // command write taken this cycle
    logic exec;    // finish command this cycle
    logic busy;    // in-progress flag
  } vcmd_strobe_t;
endpackage

// File: rtl/vcmd_ctrl.sv
module vcmd_ctrl
  import vcmd_pkg::*;
#(
  parameter int PROC_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdWrReq,
  input  logic         capEn,
  output vcmd_strobe_t strobe
);
  localparam int CNT_W = (PROC_CYCLES > 1) ? $clog2(PROC_CYCLES) : 1;

  logic             busy;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobe.busy   = busy;
    strobe.accept = cmdWrReq && capEn && !busy;
    strobe.exec   = busy && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strobe.accept) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(PROC_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/vcmd_datapath.sv
module vcmd_datapath
  import vcmd_pkg::*;
#(
  parameter int POOL_SIZE = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  vcmd_strobe_t strobe,
  input  logic         wrWide,
  input  logic         wrHi,
  input  logic [63:0]  wrData,
  output logic [63:0]  cmdWord,
  output logic [63:0]  rspWord
);
  localparam int IDX_W = $clog2(POOL_SIZE);
  localparam logic [ID_W-1:0] ID_TOP = ID_W'(POOL_SIZE - 1);

  logic [63:0]          cmdReg;
  logic [63:0]          rspReg;
  logic [POOL_SIZE-1:0] usedMap;

  logic [7:0]      opCode;
  logic [ID_W-1:0] freeId;
  logic            freeInRange;
  logic            freeOk;
  logic            found;
  logic [IDX_W-1:0] lowIdx;
  logic [1:0]      status;
  logic [ID_W-1:0] result;
  logic [63:0]     rspNext;

  assign opCode      = cmdReg[7:0];
  assign freeId      = cmdReg[27:8];
  assign freeInRange = (freeId != '0) && (freeId <= ID_TOP);
  assign freeOk      = freeInRange && usedMap[freeId[IDX_W-1:0]];

  // lowest free identifier, skipping reserved 0
  always_comb begin
    found  = 1'b0;
    lowIdx = '0;
    for (int i = POOL_SIZE - 1; i >= 1; i--) begin
      if (!usedMap[i]) begin
        found  = 1'b1;
        lowIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    status = ST_UNDEF;
    result = '0;
    case (opCode)
      OP_ALLOC: begin
        status = found ? ST_OK : ST_FAIL;
        result = found ? ID_W'(lowIdx) : '0;
      end
      OP_FREE:  status = freeOk ? ST_OK : ST_FAIL;
      default:  status = ST_UNDEF;
    endcase
    rspNext        = '0;
    rspNext[2:1]   = status;
    rspNext[27:8]  = result;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      rspReg  <= '0;
      usedMap <= '0;
    end else if (strobe.accept) begin
      if (wrWide)    cmdReg <= wrData;
      else if (wrHi) cmdReg <= {wrData[31:0], cmdReg[31:0]};
      else           cmdReg <= {cmdReg[63:32], wrData[31:0]};
      rspReg <= '0;
    end else if (strobe.exec) begin
      rspReg <= rspNext;
      if (opCode == OP_ALLOC && found) usedMap[lowIdx] <= 1'b1;
      if (opCode == OP_FREE && freeOk) usedMap[freeId[IDX_W-1:0]] <= 1'b0;
    end
  end

  assign cmdWord = cmdReg;
  assign rspWord = {rspReg[63:1], strobe.busy};
endmodule

// File: rtl/vcmd_pasid_unit.sv
module vcmd_pasid_unit
  import vcmd_pkg::*;
#(
  parameter int POOL_SIZE   = 64,
  parameter int PROC_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        capEn,
  input  logic        regWrEn,
  input  logic        regWide,
  input  logic [11:0] regAddr,
  input  logic [63:0] regWrData,
  output logic [63:0] regRdData
);
  vcmd_strobe_t strobe;
  logic [63:0]  cmdWord;
  logic [63:0]  rspWord;
  logic [63:0]  fullWord;
  logic [11:0]  baseAddr;
  logic         hiHalf;
  logic         cmdWrReq;

  assign baseAddr = regAddr & ~12'h004;
  assign hiHalf   = regAddr[2];
  assign cmdWrReq = regWrEn && (baseAddr == CMD_OFS);

  vcmd_ctrl #(.PROC_CYCLES(PROC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrReq(cmdWrReq), .capEn(capEn), .strobe(strobe)
  );

  vcmd_datapath #(.POOL_SIZE(POOL_SIZE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrWide(regWide), .wrHi(hiHalf),
    .wrData(regWrData), .cmdWord(cmdWord), .rspWord(rspWord)
  );

  always_comb begin
    case (baseAddr)
      CAP_OFS: fullWord = {63'b0, capEn};
      CMD_OFS: fullWord = cmdWord;
      RSP_OFS: fullWord = rspWord;
      default: fullWord = '0;
    endcase
    if (regWide)     regRdData = fullWord;
    else if (hiHalf) regRdData = {32'b0, fullWord[63:32]};
    else             regRdData = {32'b0, fullWord[31:0]};
  end
endmodule

// File: rtl/vcmd_pasid_chk.sv
module vcmd_pasid_chk #(
  parameter int PROC_CYCLES = 3
) (
  input logic        clk,
  input logic        rstN,
  input logic        capEn,
  input logic        cmdWrReq,
  input logic [63:0] cmdWord,
  input logic        rspIp,
  input logic [1:0]  rspStatus,
  input logic [19:0] rspResult
);
  int ipRun;

  always_ff @(posedge clk) begin
    if (!rstN)      ipRun <= 0;
    else if (rspIp) ipRun <= ipRun + 1;
    else            ipRun <= 0;
  end

  // R3
  ip_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspIp |-> (ipRun < PROC_CYCLES));

  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspIp && cmdWrReq) |=> $stable(cmdWord));

  // R5
  cap_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!capEn && cmdWrReq && !rspIp) |=> (!rspIp && $stable(cmdWord)));

  // R7
  zero_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rspIp) && cmdWord[7:0] == 8'd1 && rspStatus == 2'd0) |-> (rspResult != 20'd0));

  // R10
  undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rspIp) && cmdWord[7:0] != 8'd1 && cmdWord[7:0] != 8'd2) |-> (rspStatus == 2'd1));
endmodule

bind vcmd_pasid_unit vcmd_pasid_chk #(.PROC_CYCLES(PROC_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .capEn(capEn), .cmdWrReq(cmdWrReq), .cmdWord(cmdWord),
  .rspIp(rspWord[0]), .rspStatus(rspWord[2:1]), .rspResult(rspWord[27:8])
);

// File: tb/vcmd_pasid_unit_test.sv
module vcmd_pasid_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {command word, expected response word}
  localparam logic [127:0] VEC [NVEC] = '{
    {64'h001, 64'h100},   // alloc -> 1
    {64'h001, 64'h200},   // alloc -> 2
    {64'h001, 64'h300},   // alloc -> 3
    {64'h202, 64'h000},   // free 2
    {64'h001, 64'h200},   // alloc reuses 2
    {64'h002, 64'h004},   // free 0 -> status 2
    {64'h502, 64'h004},   // free 5 not allocated
    {64'h4002, 64'h004},  // free 64 out of range
    {64'h000, 64'h002},   // op 0 undefined
    {64'h007, 64'h002},   // op 7 undefined
    {64'h102, 64'h000},   // free 1
    {64'h001, 64'h100}    // alloc reuses 1
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capEn = 1'b1;
  logic        regWrEn = 1'b0;
  logic        regWide = 1'b1;
  logic [11:0] regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  vcmd_pasid_unit #(.POOL_SIZE(64), .PROC_CYCLES(3)) uut (
    .clk(clk), .rstN(rstN), .capEn(capEn), .regWrEn(regWrEn), .regWide(regWide),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic wide, input logic [11:0] a, output logic [63:0] d);
    regWide = wide;
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wr(input logic wide, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWide = wide;
    regAddr = a;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitDone();
    logic [63:0] r;
    for (int k = 0; k < 50; k++) begin
      rd(1'b1, 12'hE20, r);
      if (r[0] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [63:0] c, input logic [63:0] expRsp, input string req);
    logic [63:0] r;
    wr(1'b1, 12'hE10, c);
    waitDone();
    rd(1'b1, 12'hE20, r);
    chk(req, r, expRsp);
  endtask

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b1, 12'hE20, r); chk("R1 rsp", r, 64'h0);
    rd(1'b1, 12'hE10, r); chk("R1 cmd", r, 64'h0);
    // R2 capability
    rd(1'b1, 12'hE00, r); chk("R2 cap", r, 64'h1);

    for (int i = 0; i < NVEC; i++) begin
      cmd(VEC[i][127:64], VEC[i][63:0], "R6 R8 R9 R10 table");
    end

    // R3 in-progress window: 3 cycles, then id 4
    wr(1'b1, 12'hE10, 64'h1);
    rd(1'b1, 12'hE20, r); chk("R3 ip c1", r, 64'h1);
    @(negedge clk); rd(1'b1, 12'hE20, r); chk("R3 ip c2", r, 64'h1);
    @(negedge clk); rd(1'b1, 12'hE20, r); chk("R3 ip c3", r, 64'h1);
    @(negedge clk); rd(1'b1, 12'hE20, r); chk("R3 done", r, 64'h400);

    // R4 write while busy is dropped
    wr(1'b1, 12'hE10, 64'h1);
    wr(1'b1, 12'hE10, 64'h302);
    waitDone();
    rd(1'b1, 12'hE20, r); chk("R4 rsp", r, 64'h500);
    rd(1'b1, 12'hE10, r); chk("R4 cmd", r, 64'h1);
    cmd(64'h302, 64'h0, "R8 free 3");
    cmd(64'h302, 64'h4, "R9 double free");

    // R11 half-word access
    wr(1'b0, 12'hE14, 64'hA5);
    waitDone();
    rd(1'b1, 12'hE20, r); chk("R11 hi write runs cmd", r, 64'h4);
    rd(1'b0, 12'hE14, r); chk("R11 hi read", r, 64'hA5);
    rd(1'b1, 12'hE10, r); chk("R11 full read", r, 64'h000000A5_00000302);
    wr(1'b0, 12'hE10, 64'h1);
    waitDone();
    rd(1'b1, 12'hE20, r); chk("R11 R6 lo write alloc", r, 64'h300);
    rd(1'b1, 12'hE10, r); chk("R11 hi kept", r, 64'h000000A5_00000001);
    rd(1'b0, 12'hE24, r); chk("R11 rsp hi", r, 64'h0);

    // R7 exhaust pool: 6..63 then failure
    for (int id = 6; id < 64; id++) begin
      cmd(64'h1, 64'(id) << 8, "R6 fill");
    end
    cmd(64'h1, 64'h4, "R7 exhausted");
    cmd(64'h3F02, 64'h0, "R8 free top");
    cmd(64'h1, 64'h3F00, "R8 top reused");

    // R5 capability off
    @(negedge clk);
    capEn = 1'b0;
    rd(1'b0, 12'hE00, r); chk("R2 cap off", r, 64'h0);
    wr(1'b1, 12'hE10, 64'h502);
    rd(1'b1, 12'hE20, r); chk("R5 rsp", r, 64'h3F00);
    rd(1'b1, 12'hE10, r); chk("R5 cmd", r, 64'h1);
    capEn = 1'b1;

    // R2 read-only registers
    wr(1'b1, 12'hE20, 64'hFFFF);
    rd(1'b1, 12'hE20, r); chk("R2 rsp ro", r, 64'h3F00);
    wr(1'b1, 12'hE00, 64'h0);
    rd(1'b1, 12'hE00, r); chk("R2 cap ro", r, 64'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule